// File: doc/BRIEF.md
# Linear Counter Chain with Carry

This block holds the linear half of a stream-cipher state: eight 32-bit counter words and one carry bit. On every step each word gains a fixed constant chosen by its position. Word 0 also takes the carry kept from the previous step. Every higher word takes the carry-out of the word below it in the same step. The carry-out of the top word is kept for the next step. Taken together, one step is a single 256-bit addition of the packed counters and the packed constants, with the kept carry as carry-in.

Software or an initialisation sequencer can write all words and the carry at once through the load port. During setup it can XOR a 256-bit mask into the words; this leaves the carry alone.

A build-time option cuts the carry chain in the middle with a register and keeps two independent counter sets, called stream 0 and stream 1. In each step cycle the lower four words of one stream advance together with the upper four words of the other. The two roles swap on the next step cycle. Each stream therefore completes one full step every two step cycles, and the carry path in any one cycle is only 128 bits long.

Top module: `ctr_chain`

## Requirements
- R1: After reset every counter word of every stream is 0 and every kept carry is 0.
- R2: With `loadEn` high, the addressed stream takes `loadCnt` as its counters (word j on bits [32j+31:32j]) and `loadCarry` as its kept carry at the next clock edge. `streamSel` picks the stream and is ignored in the unsplit build.
- R3: A step replaces the counters C with (C + K + c) mod 2^256, where c is the kept carry. K is the packed constant vector, with word j on bits [32j+31:32j].
- R4: The carry-out of bit 255 of that sum becomes the new kept carry and is the carry-in of the next step. A word of all ones with a carry-in passes the carry to the word above it.
- R5: The constant for words 0, 3 and 6 is 0x4D34D34D. The constant for words 1, 4 and 7 is 0xD34D34D3. The constant for words 2 and 5 is 0x34D34D34.
- R6: Priority is load, then mix, then step. When load is asserted, a mix or step in the same cycle has no effect.
- R7: With `mixEn` high and `loadEn` low, the addressed stream's counters become C XOR `mixMask`. Its kept carry is unchanged and a step in the same cycle has no effect.
- R8: With no load, mix or step asserted, counters and carries hold their values.
- R9: In the split build the carry out of word 3 is registered, and step cycles alternate as follows. The first step cycle after a load advances the lower half of stream 0 only. After that, each step cycle advances the lower half of one stream and the upper half of the other, with the roles swapping every step cycle. The registered carry from the previous step cycle feeds the upper half.
- R10: In the split build a load resets the schedule. The next step cycle updates only the lower half of stream 0 and leaves every word of stream 1 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Parallel load of the counters and carry of the addressed stream |
| stepEn | input | 1 | Advance the counters by one step (split build: one half-step cycle) |
| mixEn | input | 1 | XOR `mixMask` into the addressed stream's counters |
| streamSel | input | 1 | Stream addressed by load and mix (split build only) |
| loadCnt | input | 256 | Counter words to load |
| loadCarry | input | 1 | Carry value to load |
| mixMask | input | 256 | Mask applied by mix |
| cntOut | output | 256 × streams | Current counters; stream s on bits [256s+255:256s] |
| carryOut | output | streams | Kept carry per stream |

## Verification
A load can arrive in the same cycle as a step or a mix, and a mix can coincide with a step. The bench asserts these strobes together on preset counters. It then expects exactly the loaded value, or the masked value with an unchanged carry, computed from the inputs and not from any step arithmetic.

In the split build, a load that arrives while a stream is half-stepped is provoked the same way. It is judged by confirming that stream 1 stays fully intact on the following step cycle.

// File: rtl/ctr_chain_pkg.sv
package ctr_chain_pkg;

  // Strobes passed from the control to the datapath each cycle
  typedef struct packed {
    logic doLoad;
    logic doMix;
    logic doStep;
    logic lowBank;    // stream whose lower half advances
    logic highBank;   // stream whose upper half advances
    logic highValid;  // upper half carries a valid registered carry
  } ctrlStrobes_t;

  // Per-position additive constant; the pattern repeats every three words
  function automatic logic [31:0] wordConst(input int j);
    case (j % 3)
      0:       return 32'h4D34D34D;
      1:       return 32'hD34D34D3;
      default: return 32'h34D34D34;
    endcase
  endfunction

endpackage

// File: rtl/ctr_chain_ctrl.sv
module ctr_chain_ctrl
  import ctr_chain_pkg::*;
#(
  parameter bit SPLIT = 1'b0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         loadEn,
  input  logic         mixEn,
  input  logic         stepEn,
  output ctrlStrobes_t strobes
);

  logic doLoad, doMix, doStep;

  assign doLoad = loadEn;
  assign doMix  = mixEn & ~loadEn;
  assign doStep = stepEn & ~loadEn & ~mixEn;

  generate
    if (SPLIT) begin : gSched
      logic phaseQ;
      logic midValidQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          phaseQ    <= 1'b0;
          midValidQ <= 1'b0;
        end else if (doLoad) begin
          phaseQ    <= 1'b0;
          midValidQ <= 1'b0;
        end else if (doStep) begin
          phaseQ    <= ~phaseQ;
          midValidQ <= 1'b1;
        end
      end

      always_comb begin
        strobes.doLoad    = doLoad;
        strobes.doMix     = doMix;
        strobes.doStep    = doStep;
        strobes.lowBank   = phaseQ;
        strobes.highBank  = ~phaseQ;
        strobes.highValid = midValidQ;
      end

      // R9
      phase_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.doStep |=> (phaseQ != $past(phaseQ)) && midValidQ);

      // R10
      load_sched_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
        strobes.doLoad |=> (!phaseQ && !midValidQ));
    end else begin : gFlat
      always_comb begin
        strobes.doLoad    = doLoad;
        strobes.doMix     = doMix;
        strobes.doStep    = doStep;
        strobes.lowBank   = 1'b0;
        strobes.highBank  = 1'b0;
        strobes.highValid = 1'b1;
      end
    end
  endgenerate

  // R6
  strobe_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.doLoad, strobes.doMix, strobes.doStep}));

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |-> (strobes.doLoad && !strobes.doMix && !strobes.doStep));

endmodule

// File: rtl/ctr_chain_dp.sv
module ctr_chain_dp
  import ctr_chain_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter bit SPLIT  = 1'b0,
  localparam int CNT_W   = WORDS * WORD_W,
  localparam int STREAMS = SPLIT ? 2 : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobes_t             strobes,
  input  logic                     streamSel,
  input  logic [CNT_W-1:0]         loadCnt,
  input  logic                     loadCarry,
  input  logic [CNT_W-1:0]         mixMask,
  output logic [STREAMS*CNT_W-1:0] cntOut,
  output logic [STREAMS-1:0]       carryOut
);

  localparam int HALF = WORDS / 2;

  logic [STREAMS*CNT_W-1:0] cntQ, cntD;
  logic [STREAMS-1:0]       carryQ, carryD;
  logic [2*CNT_W-1:0]       cntPad;
  logic [1:0]               carryPad;
  logic [WORDS:0]           chainC;
  logic [WORD_W-1:0]        srcW [WORDS];
  logic [WORD_W-1:0]        sumW [WORDS];
  logic                     hiCarryIn;

  assign cntPad   = (2*CNT_W)'(cntQ);
  assign carryPad = 2'(carryQ);
  assign chainC[0] = carryPad[strobes.lowBank];

  // Carry chain: one adder per word, cut at HALF in the split build
  generate
    for (genvar j = 0; j < WORDS; j++) begin : gWord
      localparam logic [WORD_W-1:0] KW = WORD_W'(wordConst(j));
      logic             cin;
      logic [WORD_W:0]  wide;

      if (SPLIT && j == HALF) begin : gCut
        assign cin = hiCarryIn;
      end else begin : gRipple
        assign cin = chainC[j];
      end

      assign srcW[j] = cntPad[((j < HALF) ? strobes.lowBank : strobes.highBank) * CNT_W
                              + j * WORD_W +: WORD_W];
      assign wide    = {1'b0, srcW[j]} + {1'b0, KW} + {{WORD_W{1'b0}}, cin};
      assign sumW[j]   = wide[WORD_W-1:0];
      assign chainC[j+1] = wide[WORD_W];
    end

    if (SPLIT) begin : gMid
      logic midQ;
      always_ff @(posedge clk) begin
        if (!rstN)                midQ <= 1'b0;
        else if (strobes.doLoad)  midQ <= 1'b0;
        else if (strobes.doStep)  midQ <= chainC[HALF];
      end
      assign hiCarryIn = midQ;
    end else begin : gNoMid
      assign hiCarryIn = chainC[HALF];
    end
  endgenerate

  always_comb begin
    cntD   = cntQ;
    carryD = carryQ;
    for (int b = 0; b < STREAMS; b++) begin
      logic selHit;
      selHit = (STREAMS == 1) || (streamSel == 1'(b));
      for (int j = 0; j < WORDS; j++) begin
        logic stepHit;
        if (j < HALF) stepHit = (strobes.lowBank == 1'(b));
        else          stepHit = (strobes.highBank == 1'(b)) && strobes.highValid;
        if (strobes.doLoad && selHit)
          cntD[b*CNT_W + j*WORD_W +: WORD_W] = loadCnt[j*WORD_W +: WORD_W];
        else if (strobes.doMix && selHit)
          cntD[b*CNT_W + j*WORD_W +: WORD_W] =
            cntQ[b*CNT_W + j*WORD_W +: WORD_W] ^ mixMask[j*WORD_W +: WORD_W];
        else if (strobes.doStep && stepHit)
          cntD[b*CNT_W + j*WORD_W +: WORD_W] = sumW[j];
      end
      if (strobes.doLoad && selHit)
        carryD[b] = loadCarry;
      else if (strobes.doStep && strobes.highValid && (strobes.highBank == 1'(b)))
        carryD[b] = chainC[WORDS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ   <= '0;
      carryQ <= '0;
    end else begin
      cntQ   <= cntD;
      carryQ <= carryD;
    end
  end

  assign cntOut   = cntQ;
  assign carryOut = carryQ;

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.doLoad && !strobes.doMix && !strobes.doStep)
      |=> ($stable(cntQ) && $stable(carryQ)));

  // R7
  mix_keeps_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doMix |=> $stable(carryQ));

  // R3
  step_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doStep |=> (cntQ != $past(cntQ)));

endmodule

// File: rtl/ctr_chain.sv
module ctr_chain
  import ctr_chain_pkg::*;
#(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32,
  parameter bit SPLIT  = 1'b0,
  localparam int CNT_W   = WORDS * WORD_W,
  localparam int STREAMS = SPLIT ? 2 : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadEn,
  input  logic                     stepEn,
  input  logic                     mixEn,
  input  logic                     streamSel,
  input  logic [CNT_W-1:0]         loadCnt,
  input  logic                     loadCarry,
  input  logic [CNT_W-1:0]         mixMask,
  output logic [STREAMS*CNT_W-1:0] cntOut,
  output logic [STREAMS-1:0]       carryOut
);

  ctrlStrobes_t strobes;

  ctr_chain_ctrl #(.SPLIT(SPLIT)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadEn  (loadEn),
    .mixEn   (mixEn),
    .stepEn  (stepEn),
    .strobes (strobes)
  );

  ctr_chain_dp #(.WORDS(WORDS), .WORD_W(WORD_W), .SPLIT(SPLIT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .streamSel (streamSel),
    .loadCnt   (loadCnt),
    .loadCarry (loadCarry),
    .mixMask   (mixMask),
    .cntOut    (cntOut),
    .carryOut  (carryOut)
  );

endmodule

// File: tb/ctr_chain_test.sv
module ctr_chain_test;

  localparam logic [255:0] KVEC = {32'hD34D34D3, 32'h4D34D34D, 32'h34D34D34, 32'hD34D34D3,
                                   32'h4D34D34D, 32'h34D34D34, 32'hD34D34D3, 32'h4D34D34D};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadEn = 0, stepEn = 0, mixEn = 0, streamSel = 0, loadCarry = 0;
  logic [255:0] loadCnt = '0, mixMask = '0;
  logic [255:0] cntA;
  logic [0:0]   carA;
  logic [511:0] cntS;
  logic [1:0]   carS;

  int nChecks = 0;
  int nFails  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctr_chain #(.SPLIT(1'b0)) uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .stepEn(stepEn), .mixEn(mixEn),
    .streamSel(streamSel), .loadCnt(loadCnt), .loadCarry(loadCarry), .mixMask(mixMask),
    .cntOut(cntA), .carryOut(carA));

  ctr_chain #(.SPLIT(1'b1)) uutSplit (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .stepEn(stepEn), .mixEn(mixEn),
    .streamSel(streamSel), .loadCnt(loadCnt), .loadCarry(loadCarry), .mixMask(mixMask),
    .cntOut(cntS), .carryOut(carS));

  function automatic logic [256:0] refStep(input logic [255:0] c, input logic ci);
    return {1'b0, c} + {1'b0, KVEC} + {256'd0, ci};
  endfunction

  task automatic check(input string req, input logic [256:0] act, input logic [256:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    loadEn = 0; stepEn = 0; mixEn = 0;
  endtask

  task automatic doLoad(input logic sel, input logic [255:0] v, input logic ci);
    idle(); loadEn = 1; streamSel = sel; loadCnt = v; loadCarry = ci;
    tick(); idle();
  endtask

  function automatic logic [255:0] pattern(input int p);
    case (p)
      0: return '0;
      1: return {256{1'b1}};
      2: return ~KVEC;
      3: return 256'h0123456789ABCDEF_FEDCBA9876543210_0F1E2D3C4B5A6978_8796A5B4C3D2E1F0;
      4: return {8{32'hB2CB2CB3}};
      default: return {32'h0, {7{32'hFFFFFFFF}}};
    endcase
  endfunction

  task automatic summary();
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [256:0] r;
    logic [255:0] cur;
    logic         cc;
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1: reset state in both builds
    check("R1", {carA, cntA}, 257'd0);
    check("R1", {1'b0, cntS[511:256]}, 257'd0);
    check("R1", {255'd0, carS}, 257'd0);

    // R5: zero counters, zero carry, one step yields the constant vector
    doLoad(0, '0, 0);
    stepEn = 1; tick(); idle();
    check("R5", {1'b0, cntA}, {1'b0, KVEC});

    // R2, R3, R4: sweep presets and carry-in, several steps each
    for (int p = 0; p < 6; p++) begin
      for (int ci = 0; ci < 2; ci++) begin
        cur = pattern(p); cc = 1'(ci);
        doLoad(0, cur, cc);
        check("R2", {carA, cntA}, {cc, cur});
        for (int s = 0; s < 8; s++) begin
          stepEn = 1; tick(); idle();
          r = refStep(cur, cc);
          cur = r[255:0]; cc = r[256];
          check("R3", {1'b0, cntA}, {1'b0, cur});
          check("R4", {256'd0, carA}, {256'd0, cc});
        end
      end
    end

    // R4: all ones with carry-in 1 ripples through all 256 bits
    doLoad(0, {256{1'b1}}, 1);
    stepEn = 1; tick(); idle();
    check("R4", {carA, cntA}, {1'b1, KVEC});

    // R6: load coincident with step and with mix
    doLoad(0, pattern(3), 0);
    loadEn = 1; stepEn = 1; loadCnt = pattern(4); loadCarry = 1; tick(); idle();
    check("R6", {carA, cntA}, {1'b1, pattern(4)});
    loadEn = 1; mixEn = 1; mixMask = {256{1'b1}}; loadCnt = pattern(2); loadCarry = 0;
    tick(); idle();
    check("R6", {carA, cntA}, {1'b0, pattern(2)});

    // R7: mix coincident with step; carry stays, step ignored
    doLoad(0, pattern(3), 1);
    mixEn = 1; stepEn = 1; mixMask = pattern(4); tick(); idle();
    check("R7", {carA, cntA}, {1'b1, pattern(3) ^ pattern(4)});

    // R8: idle cycles hold
    repeat (3) tick();
    check("R8", {carA, cntA}, {1'b1, pattern(3) ^ pattern(4)});

    // R9: split build, two streams interleaved
    for (int p = 1; p < 6; p += 2) begin
      logic [255:0] aVal, bVal, aNext, bNext, expA, expB;
      logic         aC, bC, aNC, bNC;
      aVal = pattern(p); aC = 1'b1; bVal = pattern(p - 1); bC = 1'b0;
      doLoad(1, bVal, bC);
      doLoad(0, aVal, aC);
      r = refStep(aVal, aC); aNext = r[255:0]; aNC = r[256];
      r = refStep(bVal, bC); bNext = r[255:0]; bNC = r[256];
      for (int m = 1; m <= 12; m++) begin
        stepEn = 1; tick(); idle();
        if (m % 2 == 1) begin
          if (m > 1) begin
            bVal = bNext; bC = bNC;
            r = refStep(bVal, bC); bNext = r[255:0]; bNC = r[256];
          end
          expA = {aVal[255:128], aNext[127:0]};
          expB = bVal;
        end else begin
          aVal = aNext; aC = aNC;
          r = refStep(aVal, aC); aNext = r[255:0]; aNC = r[256];
          expA = aVal;
          expB = {bVal[255:128], bNext[127:0]};
        end
        check("R9", {1'b0, cntS[255:0]}, {1'b0, expA});
        check("R9", {1'b0, cntS[511:256]}, {1'b0, expB});
        check("R9", {255'd0, carS}, {255'd0, bC, aC});
      end
    end

    // R10: load mid-schedule; next step touches only stream 0 lower half
    begin
      logic [255:0] bHold;
      doLoad(1, pattern(4), 0);
      doLoad(0, pattern(3), 0);
      repeat (2) begin stepEn = 1; tick(); idle(); end
      doLoad(0, pattern(1), 1);
      bHold = cntS[511:256];
      stepEn = 1; tick(); idle();
      r = refStep(pattern(1), 1'b1);
      check("R10", {1'b0, cntS[511:256]}, {1'b0, bHold});
      check("R10", {1'b0, cntS[255:0]}, {1'b0, pattern(1)[255:128], r[127:0]});
    end

    done = 1;
    summary();
    $finish;
  end

endmodule